// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a CPU load-store port and a burst memory bus. It holds 128-bit lines in a two-way set-associative array. Each set has one least-recently-used bit, and each line has one valid bit and one modified bit. A request carries a halfword-aligned byte address and eight byte enables. Byte lane i of the data buses refers to address `cpu_addr + i`. A request may run past the end of one line into the next. The CPU holds `cpu_req` and all request fields steady until `cpu_ready` is high, and drops the request after that edge.

Hits need no memory traffic. Stores merge into the cached copy and mark the line modified. On a miss the controller chooses a way to replace:

- If the chosen line is modified, the controller first writes the whole line to memory in a two-beat burst.
- It then reads the whole missing line in a two-beat burst, and the double-word that holds the requested data comes first.
- After the refill it replays the lookup, which now hits.

On the bus, `bus_req`, `bus_we` and `bus_addr` stay constant for a whole burst. Every cycle with `bus_ack` high completes one 64-bit beat.

Top module: `wbc_cache`

## Requirements
- R1: A request whose enabled bytes all lie inside one line, and which hits, raises `cpu_ready` in the same cycle it is presented. On a load, lane i returns the byte at `cpu_addr + i`.
- R2: A request whose highest enabled byte lies past the end of its line, with both lines present, raises `cpu_ready` exactly one cycle after it is presented. Lanes below the boundary come from the first line and the rest from the next line.
- R3: A store hit writes only the enabled bytes into the cached line and marks that line modified. It starts no bus transfer, so memory keeps its old bytes until the line is evicted.
- R4: A miss in a set that has an invalid way fills that way with a read burst only, and no write burst.
- R5: When both ways of a set are valid, a miss replaces the way whose last hit or fill is older. Every hit and every fill makes its way the most recent one.
- R6: A clean victim is dropped. The read burst starts in the cycle after the miss is seen, so a clean single-line miss returns `cpu_ready` three cycles after the request is presented.
- R7: A modified victim is written back before the refill as a burst of two beats: bytes 0-7 then bytes 8-15. The burst address is the victim line base. The single-line miss then completes after five wait cycles.
- R8: A refill read burst requests the double-word holding the first requested byte first, with `bus_addr[3]` selecting it, and then the other double-word of the same line.
- R9: Each missing line costs exactly one read burst, and no other line is fetched. A line-crossing request that misses on both lines performs two read bursts and completes after seven wait cycles.
- R10: During a burst, `bus_req` stays high and `bus_addr`/`bus_we` stay constant until the second `bus_ack`. Every burst occupies exactly two request cycles.
- R11: During and right after reset, no line is valid, `cpu_ready` is low and `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Load-store request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of lane 0, halfword aligned |
| cpu_be | input | 8 | Byte enables, lane i = address + i |
| cpu_wdata | input | 64 | Store data, lane i in bits 8i+7:8i |
| cpu_rdata | output | 64 | Load data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Request completes at this clock edge |
| bus_req | output | 1 | Burst in progress |
| bus_we | output | 1 | 1 = writeback burst, 0 = refill burst |
| bus_addr | output | ADDR_W | Address of the first beat |
| bus_wdata | output | 64 | Writeback data for the current beat |
| bus_ack | input | 1 | Current beat accepted or returned |
| bus_rdata | input | 64 | Refill data for the current beat |

## Verification
The lookup and merge path is exercised with several kinds of request, and each kind separates a different fault:

- Full-width loads at different halfword offsets expose lane-to-byte mapping errors.
- Narrow requests ending exactly on the last byte of a line show whether the line-crossing test uses the highest enabled byte or the raw window.
- Stores that cross a line boundary, read back afterwards, show whether each half lands in the correct line.

A fixed miss sequence, with hits placed between the misses, walks one set through cold fill, clean eviction and dirty eviction. The wait counts and burst counts then tell an LRU fault apart from a write-back fault. The write data and first-beat addresses captured on the bus separate a wrong critical-word order from a wrong victim address.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   localparam int LINE_BYTES = 16;
   localparam int DW_BYTES   = 8;
   localparam int OFF_W      = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SPAN  = 2'd1,
      ST_EVICT = 2'd2,
      ST_FILL  = 2'd3
   } wbc_state_e;
endpackage

// File: rtl/wbc_tags.sv
module wbc_tags #(
   parameter int SETS  = 8,
   parameter int SET_W = 3,
   parameter int TAG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic             hit_way,
   output logic             vic_way,
   output logic             vic_dirty,
   output logic [TAG_W-1:0] vic_tag,
   input  logic             touch_en,
   input  logic             touch_store,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic             fill_way,
   input  logic [TAG_W-1:0] fill_tag
);
   localparam int WAYS = 2;

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  valid_q [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];
   logic [SETS-1:0]  lru_q;
   logic [WAYS-1:0]  way_hit;

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0 || (1 << SET_W) != SETS) begin : g_bad_sets
         $error("wbc_tags: SETS must be a power of two, at least 2, matching SET_W");
      end
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign way_hit[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      end
   endgenerate

   assign hit     = |way_hit;
   assign hit_way = way_hit[1];

   always_comb begin
      if (!valid_q[lk_set][0])      vic_way = 1'b0;
      else if (!valid_q[lk_set][1]) vic_way = 1'b1;
      else                          vic_way = lru_q[lk_set];
   end
   assign vic_dirty = valid_q[lk_set][vic_way] && dirty_q[lk_set][vic_way];
   assign vic_tag   = tag_q[lk_set][vic_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
         lru_q <= '0;
      end else if (fill_en) begin
         valid_q[fill_set][fill_way] <= 1'b1;
         dirty_q[fill_set][fill_way] <= 1'b0;
         lru_q[fill_set]             <= ~fill_way;
      end else if (touch_en) begin
         lru_q[lk_set] <= ~hit_way;
         if (touch_store) dirty_q[lk_set][hit_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
   end

   // R5: an address can live in at most one way of its set
   assert_single_way_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(way_hit[0] && way_hit[1]));

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_chk
         // R3: a modified mark only ever sits on a valid line
         assert_dirty_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dirty_q[s] & ~valid_q[s]) == '0);
      end
   endgenerate
endmodule

// File: rtl/wbc_data.sv
module wbc_data #(
   parameter int SETS  = 8,
   parameter int SET_W = 3
) (
   input  logic             clk,
   input  logic [SET_W-1:0] rd_set,
   input  logic             rd_way,
   output logic [127:0]     rd_line,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic             wr_way,
   input  logic [15:0]      wr_mask,
   input  logic [127:0]     wr_line
);
   localparam int WAYS  = 2;
   localparam int BYTES = wbc_pkg::LINE_BYTES;

   logic [8*BYTES-1:0] line_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int j = 0; j < BYTES; j++) begin
            if (wr_mask[j]) line_q[wr_set][wr_way][8*j +: 8] <= wr_line[8*j +: 8];
         end
      end
   end

   assign rd_line = line_q[rd_set][rd_way];
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache #(
   parameter int ADDR_W = 20,
   parameter int SETS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_be,
   input  logic [63:0]       cpu_wdata,
   output logic [63:0]       cpu_rdata,
   output logic              cpu_ready,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [63:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [63:0]       bus_rdata
);
   import wbc_pkg::*;

   localparam int SET_W  = $clog2(SETS);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int TAG_W  = LINE_W - SET_W;

   generate
      if (TAG_W < 1) begin : g_bad_addr
         $error("wbc_cache: ADDR_W too small for SETS");
      end
   endgenerate

   wbc_state_e        state_q;
   logic              beat_q, ret_span_q, fill_way_q, crit_q;
   logic [LINE_W-1:0] fill_line_q;
   logic [TAG_W-1:0]  vtag_q;
   logic [63:0]       part_q;

   logic [OFF_W-1:0]  off;
   logic [2:0]        hi;
   logic [4:0]        end_pos;
   logic              span, in_span, lookup_st, hit_go;
   logic [LINE_W-1:0] line_a, line_b, look;
   logic [SET_W-1:0]  lk_set, rd_set, wr_set;
   logic [TAG_W-1:0]  lk_tag, vic_tag;
   logic              hit, hit_way, vic_way, vic_dirty, rd_way, wr_way;
   logic [127:0]      rd_line, st_line, wr_line;
   logic [15:0]       st_mask, wr_mask;
   logic [63:0]       lane_rdata;
   logic              fill_wr, fill_done, st_en, wr_en;

   assign off = cpu_addr[OFF_W-1:0];
   always_comb begin
      hi = 3'd0;
      for (int i = 0; i < 8; i++) if (cpu_be[i]) hi = 3'(i);
   end
   assign end_pos = {1'b0, off} + {2'b00, hi};
   assign span    = end_pos[4];

   assign line_a    = cpu_addr[ADDR_W-1:OFF_W];
   assign line_b    = line_a + 1'b1;
   assign in_span   = (state_q == ST_SPAN);
   assign lookup_st = (state_q == ST_IDLE) || in_span;
   assign look      = in_span ? line_b : line_a;
   assign lk_set    = look[SET_W-1:0];
   assign lk_tag    = look[LINE_W-1:SET_W];

   wbc_tags #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_tag(lk_tag),
      .hit(hit), .hit_way(hit_way), .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
      .touch_en(hit_go), .touch_store(cpu_we && (|st_mask)),
      .fill_en(fill_done), .fill_set(fill_line_q[SET_W-1:0]), .fill_way(fill_way_q),
      .fill_tag(fill_line_q[LINE_W-1:SET_W]));

   assign rd_set = (state_q == ST_EVICT) ? fill_line_q[SET_W-1:0] : lk_set;
   assign rd_way = (state_q == ST_EVICT) ? fill_way_q : hit_way;

   assign hit_go    = cpu_req && lookup_st && hit;
   assign cpu_ready = hit_go && (in_span || !span);
   assign st_en     = hit_go && cpu_we;

   // lane i maps to line byte off+i; bit 4 of that sum says which line owns it
   always_comb begin
      lane_rdata = part_q;
      st_mask    = '0;
      st_line    = '0;
      for (int i = 0; i < 8; i++) begin
         logic [4:0] pos;
         logic       mine;
         pos  = {1'b0, off} + 5'(i);
         mine = in_span ? pos[4] : !pos[4];
         if (mine) begin
            lane_rdata[8*i +: 8]                = rd_line[{pos[3:0], 3'b000} +: 8];
            st_mask[pos[3:0]]                   = cpu_be[i];
            st_line[{pos[3:0], 3'b000} +: 8]    = cpu_wdata[8*i +: 8];
         end
      end
   end
   assign cpu_rdata = lane_rdata;

   assign fill_wr   = (state_q == ST_FILL) && bus_ack;
   assign fill_done = fill_wr && beat_q;
   assign wr_en     = fill_wr || st_en;
   assign wr_set    = fill_wr ? fill_line_q[SET_W-1:0] : lk_set;
   assign wr_way    = fill_wr ? fill_way_q : hit_way;
   assign wr_mask   = fill_wr ? ((crit_q ^ beat_q) ? 16'hFF00 : 16'h00FF) : st_mask;
   assign wr_line   = fill_wr ? {bus_rdata, bus_rdata} : st_line;

   wbc_data #(.SETS(SETS), .SET_W(SET_W)) u_data (
      .clk(clk), .rd_set(rd_set), .rd_way(rd_way), .rd_line(rd_line),
      .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_mask(wr_mask), .wr_line(wr_line));

   assign bus_req   = (state_q == ST_EVICT) || (state_q == ST_FILL);
   assign bus_we    = (state_q == ST_EVICT);
   assign bus_addr  = bus_we ? {vtag_q, fill_line_q[SET_W-1:0], {OFF_W{1'b0}}}
                             : {fill_line_q, crit_q, 3'b000};
   assign bus_wdata = beat_q ? rd_line[127:64] : rd_line[63:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         beat_q      <= 1'b0;
         ret_span_q  <= 1'b0;
         fill_way_q  <= 1'b0;
         crit_q      <= 1'b0;
         fill_line_q <= '0;
         vtag_q      <= '0;
         part_q      <= '0;
      end else begin
         case (state_q)
            ST_IDLE, ST_SPAN: begin
               if (cpu_req && !hit) begin
                  fill_line_q <= look;
                  fill_way_q  <= vic_way;
                  vtag_q      <= vic_tag;
                  crit_q      <= in_span ? 1'b0 : cpu_addr[3];
                  ret_span_q  <= in_span;
                  beat_q      <= 1'b0;
                  state_q     <= vic_dirty ? ST_EVICT : ST_FILL;
               end else if (hit_go && !in_span && span) begin
                  part_q  <= lane_rdata;
                  state_q <= ST_SPAN;
               end else if (hit_go && in_span) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_EVICT: begin
               if (bus_ack) begin
                  beat_q <= ~beat_q;
                  if (beat_q) state_q <= ST_FILL;
               end
            end
            default: begin
               if (bus_ack) begin
                  beat_q <= ~beat_q;
                  if (beat_q) state_q <= ret_span_q ? ST_SPAN : ST_IDLE;
               end
            end
         endcase
      end
   end

   // R10: burst request, address and direction hold until the second beat
   assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !(bus_ack && beat_q)) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R7: a finished writeback is followed at once by a refill burst
   assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_ack && beat_q) |=> (bus_req && !bus_we));

   // R6: a miss on a clean or empty victim starts reading in the next cycle
   assert_clean_miss_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_st && cpu_req && !hit && !vic_dirty) |=> (bus_req && !bus_we));

   // R7: a miss on a modified victim starts a write burst in the next cycle
   assert_dirty_miss_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_st && cpu_req && !hit && vic_dirty) |=> (bus_req && bus_we));
endmodule

// File: tb/wbc_cache_test.sv
module wbc_cache_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int NS = 4;
   localparam int NV = 21;
   localparam int VW = 106;

   // {we, addr, be, wdata, waits, wr bursts, rd bursts, {check, first read addr}}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 12'h008, 8'hFF, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h1008},
      {1'b0, 12'h000, 8'hFF, 64'h0,                   4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b1, 12'h002, 8'h0F, 64'h0000_0000_A1B2_C3D4, 4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h000, 8'hFF, 64'h0,                   4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h040, 8'hFF, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h1040},
      {1'b0, 12'h004, 8'hFF, 64'h0,                   4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h080, 8'hFF, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h1080},
      {1'b0, 12'h000, 8'hFF, 64'h0,                   4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h0C8, 8'hFF, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h10C8},
      {1'b0, 12'h040, 8'hFF, 64'h0,                   4'd5, 2'd1, 2'd1, 13'h1040},
      {1'b0, 12'h01A, 8'hFF, 64'h0,                   4'd7, 2'd0, 2'd2, 13'h1020},
      {1'b0, 12'h01A, 8'hFF, 64'h0,                   4'd1, 2'd0, 2'd0, 13'h0000},
      {1'b1, 12'h01C, 8'hFF, 64'h1122_3344_5566_7788, 4'd1, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h01C, 8'hFF, 64'h0,                   4'd1, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h01E, 8'h03, 64'h0,                   4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h038, 8'h0C, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h1038},
      {1'b0, 12'h072, 8'hFF, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h1070},
      {1'b1, 12'h0B2, 8'hFF, 64'hDEAD_BEEF_0BAD_F00D, 4'd3, 2'd0, 2'd1, 13'h10B0},
      {1'b0, 12'h0B0, 8'hFF, 64'h0,                   4'd0, 2'd0, 2'd0, 13'h0000},
      {1'b0, 12'h030, 8'hFF, 64'h0,                   4'd3, 2'd0, 2'd1, 13'h1030},
      {1'b0, 12'h0F0, 8'hFF, 64'h0,                   4'd5, 2'd1, 2'd1, 13'h10F0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [7:0]    cpu_be = '0;
   logic [63:0]   cpu_wdata = '0;
   logic [63:0]   cpu_rdata;
   logic          cpu_ready;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [63:0]   bus_wdata;
   logic          bus_ack = 1'b0;
   logic [63:0]   bus_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wbc_cache #(.ADDR_W(AW), .SETS(NS)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   logic [7:0]    mem  [4096];
   logic [7:0]    refm [4096];
   int            n_checks = 0, n_errs = 0;
   int            wr_bursts = 0, rd_bursts = 0, req_cycles = 0;
   logic [AW-1:0] last_rd_addr = '0, last_wr_addr = '0;
   logic          bm_beat = 1'b0;

   function automatic logic [7:0] init_b(int a);
      return 8'(a * 29 + (a >> 8) * 71 + 5);
   endfunction

   // memory model: each negedge with a request is one completed beat
   always @(negedge clk) begin
      if (rst_n && bus_req) begin
         bus_ack = 1'b1;
         req_cycles++;
         if (bus_we) begin
            for (int b = 0; b < 8; b++)
               mem[{bus_addr[11:4], bm_beat, 3'b000} + b] = bus_wdata[8*b +: 8];
            if (!bm_beat) last_wr_addr = bus_addr;
            else wr_bursts++;
         end else begin
            for (int b = 0; b < 8; b++)
               bus_rdata[8*b +: 8] = mem[(bm_beat ? (bus_addr ^ 12'h008) : bus_addr) + b];
            if (!bm_beat) last_rd_addr = bus_addr;
            else rd_bursts++;
         end
         bm_beat = ~bm_beat;
      end else begin
         bus_ack = 1'b0;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   endtask

   task automatic access(input logic we, input logic [AW-1:0] a, input logic [7:0] be,
                         input logic [63:0] wd, output logic [63:0] rd, output int waits);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
      waits = 0;
      forever begin
         #1;
         if (cpu_ready) break;
         if (waits > 60) break;
         @(negedge clk);
         waits++;
      end
      rd = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 1'b0;
   endtask

   function automatic string wait_tag(int w);
      if (w == 1) return "R2";
      if (w == 3) return "R6";
      if (w == 5) return "R7";
      if (w == 7) return "R9";
      return "R1";
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_errs++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int a = 0; a < 4096; a++) begin
         mem[a]  = init_b(a);
         refm[a] = init_b(a);
      end
      cpu_req = 1'b1;
      cpu_addr = '0;
      cpu_be = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "ready in reset", 64'(cpu_ready), 64'd0);
      chk("R11", "bus_req in reset", 64'(bus_req), 64'd0);
      cpu_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R11", "bus_req after reset", 64'(bus_req), 64'd0);

      for (int k = 0; k < NV; k++) begin
         logic          v_we;
         logic [AW-1:0] v_addr;
         logic [7:0]    v_be;
         logic [63:0]   v_wd, got, exp, msk;
         logic [3:0]    v_waits;
         logic [1:0]    v_wr, v_rd;
         logic [12:0]   v_first;
         int            wr0, rd0, rq0, waits;
         {v_we, v_addr, v_be, v_wd, v_waits, v_wr, v_rd, v_first} = VEC[k];
         wr0 = wr_bursts; rd0 = rd_bursts; rq0 = req_cycles;
         access(v_we, v_addr, v_be, v_wd, got, waits);
         exp = '0; msk = '0;
         for (int i = 0; i < 8; i++) begin
            if (v_be[i]) begin
               msk[8*i +: 8] = 8'hFF;
               exp[8*i +: 8] = refm[(int'(v_addr) + i) % 4096];
               if (v_we) refm[(int'(v_addr) + i) % 4096] = v_wd[8*i +: 8];
            end
         end
         if (!v_we) chk((v_waits == 4'd1) ? "R2" : "R1", "load data", got & msk, exp);
         chk(wait_tag(int'(v_waits)), "wait cycles", 64'(waits), 64'(v_waits));
         chk("R7", "write bursts", 64'(wr_bursts - wr0), 64'(v_wr));
         chk("R9", "read bursts", 64'(rd_bursts - rd0), 64'(v_rd));
         chk("R10", "request cycles", 64'(req_cycles - rq0), 64'(2 * (int'(v_wr) + int'(v_rd))));
         if (v_first[12]) chk("R8", "first beat address", 64'(last_rd_addr), 64'(v_first[11:0]));

         if (k == 2) chk("R3", "memory untouched by store hit", 64'(mem[12'h002]), 64'(init_b(2)));
         if (k == 4) chk("R4", "fill into empty way wrote nothing", 64'(wr_bursts), 64'd0);
         if (k == 7) chk("R5", "recent line kept, no refill", 64'(rd_bursts - rd0), 64'd0);
         if (k == 6) chk("R6", "clean victim dropped", 64'(wr_bursts - wr0), 64'd0);
         if (k == 9) begin
            logic [63:0] m_lo, m_hi, r_lo, r_hi;
            for (int b = 0; b < 8; b++) begin
               m_lo[8*b +: 8] = mem[b];      r_lo[8*b +: 8] = refm[b];
               m_hi[8*b +: 8] = mem[8 + b];  r_hi[8*b +: 8] = refm[8 + b];
            end
            chk("R7", "written back bytes 0-7", m_lo, r_lo);
            chk("R7", "written back bytes 8-15", m_hi, r_hi);
            chk("R7", "writeback address", 64'(last_wr_addr), 64'h000);
         end
         if (k == 10) chk("R9", "no prefetch beyond two lines", 64'(rd_bursts), 64'd7);
         if (k == 20) begin
            logic [63:0] m_wb, r_wb;
            for (int b = 0; b < 8; b++) begin
               m_wb[8*b +: 8] = mem[12'h0B0 + b];
               r_wb[8*b +: 8] = refm[12'h0B0 + b];
            end
            chk("R7", "allocated store written back", m_wb, r_wb);
            chk("R7", "second writeback address", 64'(last_wr_addr), 64'h0B0);
         end
      end
      finish_run();
   end
endmodule